// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block is the host-side controller that takes a high-speed data converter from power-up to live data. After a start request it waits for the reference clock to be declared stable, then holds the converter's active-low reset pin low for a minimum time. The minimum is given in picoseconds and converted into system clock cycles when the block is elaborated. It then programs a burst of configuration registers through a simple write request/acknowledge port. The last write of that burst puts the delay-lock loop's delay-range field into the DLL control register and sets its restart bit.

The sequencer then waits for an input that declares the converter's data clock stable. Only then does it write the DLL control register again with the restart bit cleared. After that it polls the converter's status register through a read request/acknowledge port until the lock bit reads 1. On lock it raises the sync output, which acts as the converter's transmit enable, and holds it high until told to stop. If lock does not appear within a programmable number of polls, the sequencer flags an error and returns to idle without ever raising sync.

Top module: `conv_init_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `cnv_rst_n_o` is 1 and `sync_o`, `data_valid_o`, `done_o`, `err_o`, `wr_req_o` and `rd_req_o` are 0.
- R2: After `start_i`, no reset pulse and no register access are issued while `refclk_ok_i` is low.
- R3: `cnv_rst_n_o` goes low one cycle after `refclk_ok_i` is sampled high in the waiting state. It stays low for exactly ceil(RST_MIN_PS / CLK_PS) cycles, which is 7 with the defaults (25000 ps, 4000 ps).
- R4: After the reset pulse, NUM_CFG writes are issued in index order. Write i goes to address CFG_BASE+i with data CFG_DATA[i*DW +: DW]. These are followed by one write to DLL_ADDR whose data has bit RESTART_BIT = 1, field [RANGE_LSB +: RANGE_W] = DLY_RANGE and all other bits 0. The defaults give addresses 0x01..0x03 with data 0x9ABC, 0x5678, 0x1234, and then 0x51 to address 0x0A.
- R5: A transfer happens in a cycle where request and acknowledge are both high. While a request is high without acknowledge, the request, address and data hold their values. Each acknowledge moves the sequence on by exactly one access.
- R6: The DLL release write to DLL_ADDR has the same range field with RESTART_BIT = 0 (0x50 by default). It is issued only once `dclk_ok_i` is high. While waiting for it, no write and no read are issued.
- R7: After the release write, reads are issued to STAT_ADDR (0x10). A read whose data has all bits of LOCK_MASK set (bit 0 by default) counts as lock. Otherwise the next read follows after POLL_GAP idle cycles.
- R8: `sync_o` and `done_o` rise one cycle after the read acknowledge that returns lock, and then stay high.
- R9: `data_valid_o` is `sync_o` AND `tx_valid_i`, and so may be high in the first cycle of sync.
- R10: `stop_i` while sync is high drops `sync_o` and `done_o` in the next cycle, and the block returns to idle.
- R11: If MAX_POLL consecutive reads return no lock, `err_o` rises one cycle after the last of them and the block goes idle without raising sync. `err_o` clears one cycle after the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset, asynchronous |
| start_i | input | 1 | Begin the bring-up sequence (sampled in idle) |
| stop_i | input | 1 | End data transmission (sampled while running) |
| refclk_ok_i | input | 1 | Converter reference clock is stable |
| dclk_ok_i | input | 1 | Converter data clock is stable |
| tx_valid_i | input | 1 | Data source has a sample for the converter |
| cnv_rst_n_o | output | 1 | Active-low reset pin of the converter |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | AW | Register write address |
| wr_data_o | output | DW | Register write data |
| wr_ack_i | input | 1 | Register write acknowledge |
| rd_req_o | output | 1 | Register read request |
| rd_addr_o | output | AW | Register read address |
| rd_ack_i | input | 1 | Register read acknowledge, qualifies rd_data_i |
| rd_data_i | input | DW | Register read data |
| sync_o | output | 1 | Sync / transmit enable to the converter |
| data_valid_o | output | 1 | Sample presented to the converter is valid |
| done_o | output | 1 | Bring-up complete, converter transmitting |
| err_o | output | 1 | Lock was not reached within the poll limit |

## Verification
Every result has a fixed latency measured from a sampled edge. The reset pulse starts one edge after `refclk_ok_i` is seen and lasts exactly seven cycles. `sync_o` follows the locking read acknowledge by one cycle. `stop_i` and the final failing read each take effect one cycle later, and `err_o` clears one cycle after `start_i`. A monitor in the bench counts rising edges. It records the cycle of the locking acknowledge and the cycle in which sync is first seen high, the number of cycles the reset pin is low, and every transfer with its address and data. The directed tasks compare those intervals and logs against the values given in the requirements. They drive inputs and read ports on the falling edge, so each sample sits half a period after the register that produced it.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;

   // Sequencer states, in bring-up order.
   typedef enum logic [3:0] {
      S_IDLE      = 4'd0,
      S_WAIT_REF  = 4'd1,
      S_RST       = 4'd2,
      S_CFG       = 4'd3,
      S_ARM       = 4'd4,
      S_WAIT_DCLK = 4'd5,
      S_RELEASE   = 4'd6,
      S_POLL      = 4'd7,
      S_GAP       = 4'd8,
      S_RUN       = 4'd9
   } seq_state_t;

   // Which kind of word the write port carries.
   typedef enum logic [1:0] {
      W_GEN = 2'd0,
      W_ARM = 2'd1,
      W_REL = 2'd2
   } wr_kind_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/cis_span_timer.sv
// Counts LEN cycles of run_i; hit_o is high in the last of them.
module cis_span_timer #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic hit_o
);
   localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

   generate
      if (LEN < 1) begin : g_len_bad
         $error("cis_span_timer: LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign hit_o = run_i && (cnt_q == CW'(LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (!hit_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cis_retry_ctr.sv
// Counts failed lock polls; last_o marks the final allowed one.
module cis_retry_ctr #(
   parameter int MAX = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int CW = (MAX > 1) ? $clog2(MAX) : 1;

   generate
      if (MAX < 1) begin : g_max_bad
         $error("cis_retry_ctr: MAX must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign last_o = (cnt_q == CW'(MAX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && !last_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cis_cfg_rom.sv
// Produces the address/data pair for each write of the bring-up.
module cis_cfg_rom
   import conv_init_pkg::*;
#(
   parameter int                    AW          = 8,
   parameter int                    DW          = 16,
   parameter int                    NUM_CFG     = 3,
   parameter int                    IW          = 2,
   parameter logic [AW-1:0]         CFG_BASE    = 8'h01,
   parameter logic [NUM_CFG*DW-1:0] CFG_DATA    = '0,
   parameter logic [AW-1:0]         DLL_ADDR    = 8'h0A,
   parameter int                    RESTART_BIT = 0,
   parameter int                    RANGE_LSB   = 4,
   parameter int                    RANGE_W     = 3,
   parameter logic [RANGE_W-1:0]    DLY_RANGE   = '0
) (
   input  wr_kind_t          kind_i,
   input  logic [IW-1:0]     idx_i,
   output logic [AW-1:0]     addr_o,
   output logic [DW-1:0]     data_o
);
   logic [AW-1:0] gen_addr [NUM_CFG];
   logic [DW-1:0] gen_data [NUM_CFG];
   logic [DW-1:0] dll_base;

   generate
      for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_word
         assign gen_addr[gi] = CFG_BASE + AW'(gi);
         assign gen_data[gi] = CFG_DATA[gi*DW +: DW];
      end
   endgenerate

   always_comb begin
      dll_base = '0;
      dll_base[RANGE_LSB +: RANGE_W] = DLY_RANGE;
   end

   always_comb begin
      unique case (kind_i)
         W_ARM: begin
            addr_o = DLL_ADDR;
            data_o = dll_base | (DW'(1) << RESTART_BIT);
         end
         W_REL: begin
            addr_o = DLL_ADDR;
            data_o = dll_base;
         end
         default: begin
            addr_o = gen_addr[idx_i];
            data_o = gen_data[idx_i];
         end
      endcase
   end
endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
   import conv_init_pkg::*;
#(
   parameter int                    CLK_PS      = 4000,
   parameter int                    RST_MIN_PS  = 25000,
   parameter int                    AW          = 8,
   parameter int                    DW          = 16,
   parameter int                    NUM_CFG     = 3,
   parameter logic [AW-1:0]         CFG_BASE    = 8'h01,
   parameter logic [NUM_CFG*DW-1:0] CFG_DATA    = 48'h1234_5678_9ABC,
   parameter logic [AW-1:0]         DLL_ADDR    = 8'h0A,
   parameter logic [AW-1:0]         STAT_ADDR   = 8'h10,
   parameter int                    RESTART_BIT = 0,
   parameter int                    RANGE_LSB   = 4,
   parameter int                    RANGE_W     = 3,
   parameter logic [RANGE_W-1:0]    DLY_RANGE   = 3'd5,
   parameter logic [DW-1:0]         LOCK_MASK   = 16'h0001,
   parameter int                    MAX_POLL    = 16,
   parameter int                    POLL_GAP    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          refclk_ok_i,
   input  logic          dclk_ok_i,
   input  logic          tx_valid_i,
   output logic          cnv_rst_n_o,
   output logic          wr_req_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   input  logic          wr_ack_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          sync_o,
   output logic          data_valid_o,
   output logic          done_o,
   output logic          err_o
);
   localparam int RST_CYC = ceil_div(RST_MIN_PS, CLK_PS);
   localparam int IW      = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

   // Elaboration-time parameter checks.
   generate
      if (CLK_PS < 1 || RST_MIN_PS < 1) begin : g_bad_time
         $error("conv_init_seq: clock period and reset width must be positive");
      end
      if (NUM_CFG < 1) begin : g_bad_cfg
         $error("conv_init_seq: NUM_CFG must be at least 1");
      end
      if (RANGE_LSB + RANGE_W > DW || RESTART_BIT >= DW) begin : g_bad_field
         $error("conv_init_seq: DLL fields do not fit in DW");
      end
      if (RESTART_BIT >= RANGE_LSB && RESTART_BIT < RANGE_LSB + RANGE_W) begin : g_overlap
         $error("conv_init_seq: restart bit overlaps the range field");
      end
      if (LOCK_MASK == '0) begin : g_bad_mask
         $error("conv_init_seq: LOCK_MASK must select at least one bit");
      end
      if (POLL_GAP < 0) begin : g_bad_gap
         $error("conv_init_seq: POLL_GAP must not be negative");
      end
   endgenerate

   seq_state_t    state_q, state_d;
   logic [IW-1:0] idx_q;
   logic          err_q;
   logic          rst_hit, gap_hit, poll_last;
   logic          locked, poll_fail;
   wr_kind_t      kind;

   // ---------------- timers and counters ----------------
   cis_span_timer #(.LEN(RST_CYC)) u_rst_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (state_q == S_RST),
      .hit_o (rst_hit)
   );

   generate
      if (POLL_GAP > 0) begin : g_gap
         cis_span_timer #(.LEN(POLL_GAP)) u_gap_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (state_q == S_GAP),
            .hit_o (gap_hit)
         );
      end else begin : g_nogap
         assign gap_hit = 1'b1;
      end
   endgenerate

   assign locked    = ((rd_data_i & LOCK_MASK) == LOCK_MASK);
   assign poll_fail = (state_q == S_POLL) && rd_ack_i && !locked;

   cis_retry_ctr #(.MAX(MAX_POLL)) u_retry (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  ((state_q != S_POLL) && (state_q != S_GAP)),
      .inc_i  (poll_fail),
      .last_o (poll_last)
   );

   // ---------------- write word selection ----------------
   always_comb begin
      unique case (state_q)
         S_ARM:     kind = W_ARM;
         S_RELEASE: kind = W_REL;
         default:   kind = W_GEN;
      endcase
   end

   cis_cfg_rom #(
      .AW          (AW),
      .DW          (DW),
      .NUM_CFG     (NUM_CFG),
      .IW          (IW),
      .CFG_BASE    (CFG_BASE),
      .CFG_DATA    (CFG_DATA),
      .DLL_ADDR    (DLL_ADDR),
      .RESTART_BIT (RESTART_BIT),
      .RANGE_LSB   (RANGE_LSB),
      .RANGE_W     (RANGE_W),
      .DLY_RANGE   (DLY_RANGE)
   ) u_rom (
      .kind_i (kind),
      .idx_i  (idx_q),
      .addr_o (wr_addr_o),
      .data_o (wr_data_o)
   );

   // ---------------- sequencer ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:      if (start_i)     state_d = S_WAIT_REF;
         S_WAIT_REF:  if (refclk_ok_i) state_d = S_RST;
         S_RST:       if (rst_hit)     state_d = S_CFG;
         S_CFG:       if (wr_ack_i && idx_q == IW'(NUM_CFG - 1)) state_d = S_ARM;
         S_ARM:       if (wr_ack_i)    state_d = S_WAIT_DCLK;
         S_WAIT_DCLK: if (dclk_ok_i)   state_d = S_RELEASE;
         S_RELEASE:   if (wr_ack_i)    state_d = S_POLL;
         S_POLL: begin
            if (rd_ack_i) begin
               if (locked)          state_d = S_RUN;
               else if (poll_last)  state_d = S_IDLE;
               else if (POLL_GAP > 0) state_d = S_GAP;
               else                 state_d = S_POLL;
            end
         end
         S_GAP:       if (gap_hit)     state_d = S_POLL;
         S_RUN:       if (stop_i)      state_d = S_IDLE;
         default:                      state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q != S_CFG) begin
            idx_q <= '0;
         end else if (wr_ack_i && idx_q != IW'(NUM_CFG - 1)) begin
            idx_q <= idx_q + 1'b1;
         end
         if (state_q == S_IDLE && start_i) begin
            err_q <= 1'b0;
         end else if (poll_fail && poll_last) begin
            err_q <= 1'b1;
         end
      end
   end

   // ---------------- outputs ----------------
   assign cnv_rst_n_o  = (state_q != S_RST);
   assign wr_req_o     = (state_q == S_CFG) || (state_q == S_ARM) || (state_q == S_RELEASE);
   assign rd_req_o     = (state_q == S_POLL);
   assign rd_addr_o    = STAT_ADDR;
   assign sync_o       = (state_q == S_RUN);
   assign done_o       = (state_q == S_RUN);
   assign data_valid_o = sync_o && tx_valid_i;
   assign err_o        = err_q;
endmodule

// File: rtl/conv_init_seq_chk.sv
module conv_init_seq_chk #(
   parameter int RST_CYC = 7,
   parameter int AW      = 8,
   parameter int DW      = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stop_i,
   input logic          cnv_rst_n_o,
   input logic          wr_req_o,
   input logic [AW-1:0] wr_addr_o,
   input logic [DW-1:0] wr_data_o,
   input logic          wr_ack_i,
   input logic          rd_req_o,
   input logic          rd_ack_i,
   input logic          sync_o,
   input logic          data_valid_o,
   input logic          err_o
);
   logic [15:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            low_cnt <= '0;
      else if (!cnv_rst_n_o) low_cnt <= low_cnt + 1'b1;
      else                   low_cnt <= '0;
   end

   AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_rst_n_o) |-> (low_cnt == 16'(RST_CYC)));                         // R3

   AST_RST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      !cnv_rst_n_o |-> (low_cnt < 16'(RST_CYC)));                                // R3

   AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cnv_rst_n_o |-> (!wr_req_o && !rd_req_o && !sync_o));                     // R4

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R5

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> rd_req_o);                                     // R7

   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_req_o, rd_req_o, sync_o}));                                   // R6

   AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_o && !stop_i) |=> sync_o);                                           // R8

   AST_SYNC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_o && stop_i) |=> !sync_o);                                           // R10

   AST_VALID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> sync_o);                                                  // R9

   AST_ERR_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !sync_o);                                                        // R11
endmodule

bind conv_init_seq conv_init_seq_chk #(
   .RST_CYC (conv_init_pkg::ceil_div(RST_MIN_PS, CLK_PS)),
   .AW      (AW),
   .DW      (DW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stop_i       (stop_i),
   .cnv_rst_n_o  (cnv_rst_n_o),
   .wr_req_o     (wr_req_o),
   .wr_addr_o    (wr_addr_o),
   .wr_data_o    (wr_data_o),
   .wr_ack_i     (wr_ack_i),
   .rd_req_o     (rd_req_o),
   .rd_ack_i     (rd_ack_i),
   .sync_o       (sync_o),
   .data_valid_o (data_valid_o),
   .err_o        (err_o)
);

// File: tb/conv_init_seq_tb.sv
module conv_init_seq_tb;
   localparam int MAXP = 6;
   localparam int GAP  = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        rst_n = 1'b0;
   logic        start = 1'b0, stop = 1'b0, refclk_ok = 1'b0, dclk_ok = 1'b0, tx_valid = 1'b0;
   logic        cnv_rst_n, wr_req, wr_ack, rd_req, rd_ack;
   logic [7:0]  wr_addr, rd_addr;
   logic [15:0] wr_data, rd_data;
   logic        sync, dvalid, done, err;

   conv_init_seq #(.MAX_POLL(MAXP), .POLL_GAP(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
      .refclk_ok_i(refclk_ok), .dclk_ok_i(dclk_ok), .tx_valid_i(tx_valid),
      .cnv_rst_n_o(cnv_rst_n), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_ack_i(wr_ack), .rd_req_o(rd_req),
      .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
      .sync_o(sync), .data_valid_o(dvalid), .done_o(done), .err_o(err)
   );

   // ---------------- converter model and monitor ----------------
   int          ack_dly = 0, lock_after = 0;
   int          wwait = 0, rwait = 0, zero_reads = 0;
   bit          armed = 1'b0;
   logic [15:0] dll_reg = '0;
   logic [7:0]  la [0:63];
   logic [15:0] ld [0:63];
   int          nwr = 0, nrd = 0, bad_rd_addr = 0, cyc = 0, low_cnt = 0;
   int          lock_cyc = 0, rise_cyc = 0, n_rise = 0, n_fall = 0, hold_bad = 0;
   bit          dv_at_rise = 1'b0, sync_q = 1'b0, wq_req = 1'b0, wq_ack = 1'b0;
   logic [7:0]  wq_addr = '0;
   logic [15:0] wq_data = '0;
   logic        lock_now;

   assign lock_now = armed && (zero_reads >= lock_after);
   assign wr_ack   = wr_req && (wwait >= ack_dly);
   assign rd_ack   = rd_req && (rwait >= ack_dly);
   assign rd_data  = {15'b0, lock_now};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!cnv_rst_n) low_cnt <= low_cnt + 1;
      if (wr_req && wr_ack) begin
         la[nwr % 64] <= wr_addr;
         ld[nwr % 64] <= wr_data;
         nwr   <= nwr + 1;
         wwait <= 0;
         if (wr_addr == 8'h0A) begin
            dll_reg    <= wr_data;
            armed      <= (wr_data[0] == 1'b0);
            zero_reads <= 0;
         end
      end else if (wr_req) wwait <= wwait + 1;
      if (rd_req && rd_ack) begin
         nrd   <= nrd + 1;
         rwait <= 0;
         if (rd_addr != 8'h10) bad_rd_addr <= bad_rd_addr + 1;
         if (lock_now) lock_cyc <= cyc;
         else          zero_reads <= zero_reads + 1;
      end else if (rd_req) rwait <= rwait + 1;
      if (wq_req && !wq_ack && (!wr_req || wr_addr != wq_addr || wr_data != wq_data))
         hold_bad <= hold_bad + 1;
      wq_req <= wr_req; wq_ack <= wr_ack; wq_addr <= wr_addr; wq_data <= wr_data;
      if (sync && !sync_q) begin
         rise_cyc <= cyc; n_rise <= n_rise + 1; dv_at_rise <= dvalid;
      end
      if (!sync && sync_q) n_fall <= n_fall + 1;
      sync_q <= sync;
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_bad = 0;

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   // R1: idle values in and after block reset
   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "rst pin in reset", cnv_rst_n, 1);
      check("R1", "outputs in reset", {sync, dvalid, done, err, wr_req, rd_req}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "outputs after reset", {cnv_rst_n, sync, dvalid, done, err, wr_req, rd_req}, 7'b1000000);
   endtask

   // R2..R9: complete bring-up with a given acknowledge delay and lock latency
   task automatic t_bringup(input int ackd, input int lk);
      int w0, r0, lo0, h0, f0, rs0;
      w0 = nwr; r0 = nrd; lo0 = low_cnt; h0 = hold_bad; f0 = n_fall; rs0 = n_rise;
      ack_dly = ackd; lock_after = lk;
      refclk_ok = 1'b0; dclk_ok = 1'b0; tx_valid = 1'b1;
      pulse_start();
      repeat (10) @(negedge clk);
      check("R2", "rst pin while refclk low", cnv_rst_n, 1);
      check("R2", "writes while refclk low", nwr - w0, 0);
      refclk_ok = 1'b1;
      @(negedge clk);
      check("R3", "rst pin one cycle after refclk_ok", cnv_rst_n, 0);
      repeat (60) @(negedge clk);
      check("R3", "reset low cycles", low_cnt - lo0, 7);
      check("R4", "config burst length", nwr - w0, 4);
      check("R4", "cfg0 addr", la[(w0 + 0) % 64], 8'h01);
      check("R4", "cfg0 data", ld[(w0 + 0) % 64], 16'h9ABC);
      check("R4", "cfg1 addr", la[(w0 + 1) % 64], 8'h02);
      check("R4", "cfg1 data", ld[(w0 + 1) % 64], 16'h5678);
      check("R4", "cfg2 addr", la[(w0 + 2) % 64], 8'h03);
      check("R4", "cfg2 data", ld[(w0 + 2) % 64], 16'h1234);
      check("R4", "arm write addr", la[(w0 + 3) % 64], 8'h0A);
      check("R4", "arm write data", ld[(w0 + 3) % 64], 16'h0051);
      check("R5", "request held until acknowledge", hold_bad - h0, 0);
      check("R6", "reads before dclk_ok", nrd - r0, 0);
      check("R6", "requests idle before dclk_ok", {wr_req, rd_req}, 0);
      check("R6", "restart bit still set", dll_reg[0], 1);
      dclk_ok = 1'b1;
      repeat ((lk + 1) * (ackd + GAP + 2) + 20) @(negedge clk);
      check("R6", "write count after release", nwr - w0, 5);
      check("R6", "release addr", la[(w0 + 4) % 64], 8'h0A);
      check("R6", "release data", ld[(w0 + 4) % 64], 16'h0050);
      check("R7", "lock reads", nrd - r0, lk + 1);
      check("R7", "read address", bad_rd_addr, 0);
      check("R8", "sync after lock", sync, 1);
      check("R8", "done after lock", done, 1);
      check("R8", "sync rise count", n_rise - rs0, 1);
      check("R8", "sync latency from lock ack", rise_cyc - lock_cyc, 1);
      check("R9", "data_valid in first sync cycle", dv_at_rise, 1);
      repeat (20) @(negedge clk);
      check("R8", "sync held", sync, 1);
      check("R8", "no sync drop", n_fall - f0, 0);
      tx_valid = 1'b0; #1;
      check("R9", "data_valid with tx_valid low", dvalid, 0);
      tx_valid = 1'b1; #1;
      check("R9", "data_valid with tx_valid high", dvalid, 1);
   endtask

   // R10: stop while running
   task automatic t_stop();
      @(negedge clk) stop = 1'b1;
      @(negedge clk) stop = 1'b0;
      check("R10", "sync after stop", sync, 0);
      check("R10", "done after stop", done, 0);
      repeat (5) @(negedge clk);
      check("R10", "idle after stop", {wr_req, rd_req, sync, ~cnv_rst_n}, 0);
   endtask

   // R11: lock never arrives
   task automatic t_poll_fail();
      int r0, rs0;
      r0 = nrd; rs0 = n_rise;
      ack_dly = 1; lock_after = 1000;
      refclk_ok = 1'b1; dclk_ok = 1'b1;
      pulse_start();
      repeat (200) @(negedge clk);
      check("R11", "error flag", err, 1);
      check("R11", "poll reads before error", nrd - r0, MAXP);
      check("R11", "sync never raised", n_rise - rs0, 0);
      check("R11", "idle after error", {wr_req, rd_req, sync, ~cnv_rst_n}, 0);
      refclk_ok = 1'b0;
      pulse_start();
      check("R11", "error cleared by start", err, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      t_reset_state();
      t_bringup(0, 0);
      t_stop();
      t_bringup(3, 2);
      t_stop();
      t_poll_fail();
      summary();
   end
endmodule